// File: doc/BRIEF.md
# I2C Master Bus Acquisition and Arbitration Unit

This unit decides when the local I2C master may take the bus and notices when it has lost the bus to another master. A host request to become master is never refused. If the bus is free and the local slave logic is idle, a start-condition pulse goes out at once. If the bus is busy, or the slave side is busy, the request is parked: the unit reports master-requested set and active clear, and it issues the start one cycle after the bus-busy flag falls.

During a master transfer the bit engine gives a sample strobe together with the level it is driving and the level it sees on SDA. When the unit releases SDA (drives 1) but sees 0, it has lost arbitration. It then drops master status, stays active so that it can be addressed as a slave, and sets a sticky arbitration-lost flag. At the wait point that the wait-select input picks, it raises the interrupt flag and holds SCL low. Being addressed as a slave while still parked also counts as arbitration loss. Any one of several host actions clears the arbitration-lost flag.

Top module: `i2c_master_arbiter`

## Requirements
- R1: After reset, and one cycle after `en` is sampled low, all outputs are 0. This includes `bus_busy`, `arb_lost`, `irq_flag` and `stop_flag`.
- R2: `bus_busy` becomes 1 the cycle after `start_det` is sampled high. It becomes 0 the cycle after `stop_det` is sampled high.
- R3: A request (`req_wr`=1, `req_val`=1) sampled in the idle state while `bus_busy`=0 and `slave_busy`=0 gives `master_req`=1 and `active`=1 on the next cycle. `start_go` is high for exactly that one cycle.
- R4: A request sampled in the idle state while `bus_busy`=1 or `slave_busy`=1 gives `master_req`=1, `active`=0 and no `start_go`. In the first cycle that this waiting state sees both flags at 0, it moves to `master_req`=1, `active`=1 with a one-cycle `start_go`, visible one cycle later.
- R5: A mismatch is counted only on a `bit_sample` cycle while transferring, with `sda_out`=1 and `sda_in`=0. The next cycle shows `master_req`=0, `active`=1 and `arb_lost`=1. Driving 0 while sampling 1 has no effect.
- R6: After a loss, `irq_flag` and `scl_hold` rise one cycle after the first `byte_end` when `wait_sel`=1, or after the first `ack_end` when `wait_sel`=0. The other strobe does not raise them.
- R7: A `slave_hit` sampled while waiting gives `arb_lost`=1, `master_req`=0 and `active`=1 on the next cycle.
- R8: `arb_lost` is cleared by any one of these: a request write with `req_val`=1; an `irq_clr` pulse, which also clears `irq_flag` and `scl_hold`; or a `stop_clr` pulse while both `stop_flag` and `arb_lost` are 1.
- R9: A `stop_clr` pulse while `stop_flag`=0 leaves `arb_lost` at 1.
- R10: A write with `req_val`=0 while waiting returns the unit to idle (0/0). The same write while transferring gives `master_req`=0, `active`=1 until `stop_det`, which returns the unit to idle.
- R11: `stop_flag` becomes 1 the cycle after `stop_det`, and 0 the cycle after `stop_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Interface enable; low clears all state |
| req_wr | input | 1 | Host write strobe for the master-request bit |
| req_val | input | 1 | Value written to the master-request bit |
| irq_clr | input | 1 | Host writes the interrupt flag to 0 |
| stop_clr | input | 1 | Host clears the stop-detected flag |
| wait_sel | input | 1 | 1: wait after the data byte; 0: wait after the acknowledge |
| start_det | input | 1 | Start condition seen on the bus |
| stop_det | input | 1 | Stop condition seen on the bus |
| slave_busy | input | 1 | Local slave logic is in a transfer |
| slave_hit | input | 1 | Local slave address matched |
| bit_sample | input | 1 | SDA sample strobe of the bit engine |
| sda_out | input | 1 | Level the master drives (1 = released) |
| sda_in | input | 1 | Sampled SDA level |
| byte_end | input | 1 | Eighth bit of a byte done |
| ack_end | input | 1 | Acknowledge bit done |
| master_req | output | 1 | Master-requested status |
| active | output | 1 | Active-on-bus status |
| start_go | output | 1 | One-cycle command to issue a start condition |
| bus_busy | output | 1 | Bus-busy flag |
| arb_lost | output | 1 | Arbitration-lost flag |
| irq_flag | output | 1 | Interrupt flag |
| scl_hold | output | 1 | Hold SCL low |
| stop_flag | output | 1 | Stop-detected flag |

## Verification
A wrong acquisition state appears on `master_req`/`active` one cycle after the request or bus event that caused it. If a start is missing or issued twice, it shows on `start_go` in the cycle after `bus_busy` is seen low. A faulty compare shows on `arb_lost` the cycle after the sample strobe. A faulty wait point shows on `irq_flag` one cycle after the wrong strobe. A bench model evaluated every clock therefore catches each fault within one cycle of its cause.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

  typedef enum logic [1:0] {
    ACQ_IDLE = 2'd0,
    ACQ_WAIT = 2'd1,
    ACQ_RUN  = 2'd2,
    ACQ_LEFT = 2'd3
  } acq_state_e;

  // Any of the host actions that release the arbitration-lost flag.
  function automatic logic al_release(input logic req_wr, input logic req_val,
                                      input logic irq_clr, input logic stop_clr,
                                      input logic stop_flag, input logic al);
    return (req_wr & req_val) | irq_clr | (stop_clr & stop_flag & al);
  endfunction

  // Strobe at which a pending loss turns into a bus wait.
  function automatic logic wait_point(input logic wait_sel, input logic byte_end,
                                      input logic ack_end);
    return wait_sel ? byte_end : ack_end;
  endfunction

endpackage

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start_det,
  input  logic stop_det,
  input  logic stop_clr,
  output logic bus_busy,
  output logic stop_flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_busy  <= 1'b0;
      stop_flag <= 1'b0;
    end else if (!en) begin
      bus_busy  <= 1'b0;
      stop_flag <= 1'b0;
    end else begin
      if (start_det)     bus_busy <= 1'b1;
      else if (stop_det) bus_busy <= 1'b0;
      if (stop_det)      stop_flag <= 1'b1;
      else if (stop_clr) stop_flag <= 1'b0;
    end
  end

  // R2
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start_det) |=> (bus_busy || !$past(en)));

  // R11
  flag_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop_det) |=> stop_flag);

endmodule

// File: rtl/i2c_acq_fsm.sv
module i2c_acq_fsm
  import i2c_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic req_wr,
  input  logic req_val,
  input  logic bus_busy,
  input  logic slave_busy,
  input  logic slave_hit,
  input  logic stop_det,
  input  logic arb_fail,
  output logic master_req,
  output logic active,
  output logic start_go,
  output logic running,
  output logic wait_hit
);

  acq_state_e st, st_nxt;
  logic       go_nxt;
  logic       hit_nxt;
  logic       want, drop, blocked;

  assign want    = req_wr & req_val;
  assign drop    = req_wr & ~req_val;
  assign blocked = bus_busy | slave_busy;

  always_comb begin
    st_nxt  = st;
    go_nxt  = 1'b0;
    hit_nxt = 1'b0;
    unique case (st)
      ACQ_IDLE: if (want) begin
        if (blocked) st_nxt = ACQ_WAIT;
        else begin
          st_nxt = ACQ_RUN;
          go_nxt = 1'b1;
        end
      end
      ACQ_WAIT: begin
        if (drop) st_nxt = ACQ_IDLE;
        else if (slave_hit) begin
          st_nxt  = ACQ_LEFT;
          hit_nxt = 1'b1;
        end else if (!blocked) begin
          st_nxt = ACQ_RUN;
          go_nxt = 1'b1;
        end
      end
      ACQ_RUN: begin
        if (arb_fail)      st_nxt = ACQ_LEFT;
        else if (stop_det) st_nxt = ACQ_IDLE;
        else if (drop)     st_nxt = ACQ_LEFT;
      end
      default: if (stop_det) st_nxt = ACQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ACQ_IDLE;
      start_go <= 1'b0;
    end else if (!en) begin
      st       <= ACQ_IDLE;
      start_go <= 1'b0;
    end else begin
      st       <= st_nxt;
      start_go <= go_nxt;
    end
  end

  assign master_req = (st == ACQ_WAIT) | (st == ACQ_RUN);
  assign active     = (st == ACQ_RUN) | (st == ACQ_LEFT);
  assign running    = (st == ACQ_RUN);
  assign wait_hit   = en & hit_nxt;

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> !start_go);

  // R4
  start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |-> (!$past(bus_busy) && !$past(slave_busy)));

  // R5
  lost_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && arb_fail) |=> (!master_req && active));

endmodule

// File: rtl/i2c_arb_detect.sv
module i2c_arb_detect
  import i2c_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic running,
  input  logic bit_sample,
  input  logic sda_out,
  input  logic sda_in,
  input  logic wait_sel,
  input  logic byte_end,
  input  logic ack_end,
  input  logic irq_clr,
  input  logic req_wr,
  input  logic req_val,
  input  logic stop_clr,
  input  logic stop_flag,
  input  logic wait_hit,
  output logic arb_fail,
  output logic arb_lost,
  output logic irq_flag,
  output logic scl_hold
);

  logic pend;
  logic at_wait;

  assign arb_fail = running & bit_sample & sda_out & ~sda_in;
  assign at_wait  = wait_point(wait_sel, byte_end, ack_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_lost <= 1'b0;
      pend     <= 1'b0;
      irq_flag <= 1'b0;
    end else if (!en) begin
      arb_lost <= 1'b0;
      pend     <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      if (arb_fail || wait_hit) arb_lost <= 1'b1;
      else if (al_release(req_wr, req_val, irq_clr, stop_clr, stop_flag, arb_lost))
        arb_lost <= 1'b0;
      if (arb_fail)            pend <= 1'b1;
      else if (pend && at_wait) pend <= 1'b0;
      if (pend && at_wait)     irq_flag <= 1'b1;
      else if (irq_clr)        irq_flag <= 1'b0;
    end
  end

  assign scl_hold = irq_flag;

  // R6
  irq_wait_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(wait_sel ? byte_end : ack_end));

  // R7
  slave_hit_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_hit |=> arb_lost);

  // R5
  no_low_drive_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_sample && !sda_out && !arb_lost && !wait_hit) |=> !arb_lost);

endmodule

// File: rtl/i2c_master_arbiter.sv
module i2c_master_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic req_wr,
  input  logic req_val,
  input  logic irq_clr,
  input  logic stop_clr,
  input  logic wait_sel,
  input  logic start_det,
  input  logic stop_det,
  input  logic slave_busy,
  input  logic slave_hit,
  input  logic bit_sample,
  input  logic sda_out,
  input  logic sda_in,
  input  logic byte_end,
  input  logic ack_end,
  output logic master_req,
  output logic active,
  output logic start_go,
  output logic bus_busy,
  output logic arb_lost,
  output logic irq_flag,
  output logic scl_hold,
  output logic stop_flag
);

  logic running;
  logic wait_hit;
  logic arb_fail;

  i2c_bus_monitor u_mon (
    .clk(clk), .rst_n(rst_n), .en(en),
    .start_det(start_det), .stop_det(stop_det), .stop_clr(stop_clr),
    .bus_busy(bus_busy), .stop_flag(stop_flag)
  );

  i2c_acq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en),
    .req_wr(req_wr), .req_val(req_val),
    .bus_busy(bus_busy), .slave_busy(slave_busy), .slave_hit(slave_hit),
    .stop_det(stop_det), .arb_fail(arb_fail),
    .master_req(master_req), .active(active), .start_go(start_go),
    .running(running), .wait_hit(wait_hit)
  );

  i2c_arb_detect u_det (
    .clk(clk), .rst_n(rst_n), .en(en),
    .running(running), .bit_sample(bit_sample),
    .sda_out(sda_out), .sda_in(sda_in),
    .wait_sel(wait_sel), .byte_end(byte_end), .ack_end(ack_end),
    .irq_clr(irq_clr), .req_wr(req_wr), .req_val(req_val),
    .stop_clr(stop_clr), .stop_flag(stop_flag), .wait_hit(wait_hit),
    .arb_fail(arb_fail), .arb_lost(arb_lost),
    .irq_flag(irq_flag), .scl_hold(scl_hold)
  );

  // R1
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!master_req && !active && !arb_lost && !irq_flag && !bus_busy));

endmodule

// File: tb/tb_i2c_master_arbiter.sv
module tb_i2c_master_arbiter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic req_wr = 0, req_val = 0, irq_clr = 0, stop_clr = 0, wait_sel = 0;
  logic start_det = 0, stop_det = 0, slave_busy = 0, slave_hit = 0;
  logic bit_sample = 0, sda_out = 0, sda_in = 0, byte_end = 0, ack_end = 0;
  logic master_req, active, start_go, bus_busy, arb_lost, irq_flag, scl_hold, stop_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_master_arbiter dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .req_wr(req_wr), .req_val(req_val), .irq_clr(irq_clr), .stop_clr(stop_clr),
    .wait_sel(wait_sel), .start_det(start_det), .stop_det(stop_det),
    .slave_busy(slave_busy), .slave_hit(slave_hit), .bit_sample(bit_sample),
    .sda_out(sda_out), .sda_in(sda_in), .byte_end(byte_end), .ack_end(ack_end),
    .master_req(master_req), .active(active), .start_go(start_go),
    .bus_busy(bus_busy), .arb_lost(arb_lost), .irq_flag(irq_flag),
    .scl_hold(scl_hold), .stop_flag(stop_flag)
  );

  // Behavioural reference: status pair, flags and a pending-wait marker.
  bit m_mst, m_act, m_go, m_busy, m_sf, m_al, m_pend, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      {m_mst, m_act, m_go, m_busy, m_sf, m_al, m_pend, m_irq} = '0;
    end else begin
      bit om, oa, obusy, osf, oal, opend, fail, hit, pt, want, drop;
      om = m_mst; oa = m_act; obusy = m_busy; osf = m_sf; oal = m_al; opend = m_pend;
      want = req_wr && req_val;
      drop = req_wr && !req_val;
      fail = om && oa && bit_sample && sda_out && !sda_in;
      hit  = 0;
      m_go = 0;
      if (start_det) m_busy = 1; else if (stop_det) m_busy = 0;
      if (stop_det) m_sf = 1; else if (stop_clr) m_sf = 0;
      if (!om && !oa) begin
        if (want) begin
          if (obusy || slave_busy) begin m_mst = 1; m_act = 0; end
          else begin m_mst = 1; m_act = 1; m_go = 1; end
        end
      end else if (om && !oa) begin
        if (drop) begin m_mst = 0; m_act = 0; end
        else if (slave_hit) begin m_mst = 0; m_act = 1; hit = 1; end
        else if (!obusy && !slave_busy) begin m_act = 1; m_go = 1; end
      end else if (om && oa) begin
        if (fail) m_mst = 0;
        else if (stop_det) begin m_mst = 0; m_act = 0; end
        else if (drop) m_mst = 0;
      end else begin
        if (stop_det) m_act = 0;
      end
      if (fail || hit) m_al = 1;
      else if (want || irq_clr || (stop_clr && osf && oal)) m_al = 0;
      pt = wait_sel ? byte_end : ack_end;
      if (fail) m_pend = 1; else if (opend && pt) m_pend = 0;
      if (opend && pt) m_irq = 1; else if (irq_clr) m_irq = 0;
    end
  end

  task automatic cmp(input logic a, input logic e, input string req, input string nm);
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, a, e, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    cmp(master_req, m_mst, "R3", "master_req model");
    cmp(active, m_act, "R4", "active model");
    cmp(start_go, m_go, "R3", "start_go model");
    cmp(bus_busy, m_busy, "R2", "bus_busy model");
    cmp(stop_flag, m_sf, "R11", "stop_flag model");
    cmp(arb_lost, m_al, "R8", "arb_lost model");
    cmp(irq_flag, m_irq, "R6", "irq_flag model");
    cmp(scl_hold, m_irq, "R6", "scl_hold model");
  end

  task automatic expect1(input logic a, input logic e, input string req, input string nm);
    checks++;
    cmp(a, e, req, nm);
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
    {req_wr, req_val, irq_clr, stop_clr, start_det, stop_det, slave_hit} = '0;
    {bit_sample, sda_out, sda_in, byte_end, ack_end} = '0;
  endtask

  task automatic request(input logic v);
    req_wr = 1; req_val = v; tick();
  endtask

  task automatic bus_start; start_det = 1; tick(); endtask
  task automatic bus_stop;  stop_det = 1; tick(); endtask
  task automatic clr_stop;  stop_clr = 1; tick(); endtask

  task automatic sample_bit(input logic drv, input logic seen);
    bit_sample = 1; sda_out = drv; sda_in = seen; tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect1(master_req | active | start_go | bus_busy | arb_lost | irq_flag | stop_flag,
            1'b0, "R1", "outputs after reset");

    // R2 / R11 bus monitor
    bus_start();
    expect1(bus_busy, 1, "R2", "busy after start");
    bus_stop();
    expect1(bus_busy, 0, "R2", "free after stop");
    expect1(stop_flag, 1, "R11", "stop flag set");
    clr_stop();
    expect1(stop_flag, 0, "R11", "stop flag cleared");

    // R3 immediate start, R5 loss, R6 wait after byte
    request(1);
    expect1(master_req & active, 1, "R3", "running after free request");
    expect1(start_go, 1, "R3", "start pulse");
    tick();
    expect1(start_go, 0, "R3", "start pulse one cycle");
    bus_start();
    sample_bit(0, 1);
    expect1(arb_lost, 0, "R5", "drive0 sample1 ignored");
    expect1(master_req, 1, "R5", "still master after drive0");
    sample_bit(1, 1);
    expect1(arb_lost, 0, "R5", "matching bit");
    sample_bit(1, 0);
    expect1(arb_lost, 1, "R5", "loss flagged");
    expect1(master_req, 0, "R5", "master dropped");
    expect1(active, 1, "R5", "stays active");
    expect1(irq_flag, 0, "R6", "no irq before wait point");
    wait_sel = 1;
    ack_end = 1; tick();
    expect1(irq_flag, 0, "R6", "ack strobe ignored when wait_sel=1");
    byte_end = 1; tick();
    expect1(irq_flag, 1, "R6", "irq at byte end");
    expect1(scl_hold, 1, "R6", "scl held");
    irq_clr = 1; tick();
    expect1(irq_flag, 0, "R8", "irq cleared");
    expect1(arb_lost, 0, "R8", "loss cleared by irq write");
    bus_stop();
    expect1(active, 0, "R10", "idle after stop");
    clr_stop();

    // R6 wait after acknowledge; R8 clear by request write
    wait_sel = 0;
    request(1);
    bus_start();
    sample_bit(1, 0);
    byte_end = 1; tick();
    expect1(irq_flag, 0, "R6", "byte strobe ignored when wait_sel=0");
    ack_end = 1; tick();
    expect1(irq_flag, 1, "R6", "irq at ack end");
    request(1);
    expect1(arb_lost, 0, "R8", "loss cleared by request write");
    irq_clr = 1; tick();
    bus_stop();
    clr_stop();

    // R4 parked request on busy bus
    bus_start();
    request(1);
    expect1(master_req, 1, "R4", "parked master_req");
    expect1(active | start_go, 0, "R4", "parked not active");
    tick();
    expect1(active, 0, "R4", "still parked");
    bus_stop();
    expect1(bus_busy, 0, "R4", "bus freed");
    expect1(active, 0, "R4", "start waits a cycle");
    tick();
    expect1(active & start_go, 1, "R4", "start after free");
    bus_start();
    // R10 release while running
    request(0);
    expect1(master_req, 0, "R10", "release drops master");
    expect1(active, 1, "R10", "active until stop");
    bus_stop();
    expect1(active, 0, "R10", "idle after stop");
    clr_stop();

    // R7 slave hit while parked; R8 clear by stop flag
    bus_start();
    request(1);
    slave_hit = 1; tick();
    expect1(arb_lost, 1, "R7", "loss on slave hit");
    expect1(master_req, 0, "R7", "master dropped");
    expect1(active, 1, "R7", "active as slave");
    bus_stop();
    expect1(arb_lost, 1, "R8", "loss kept after stop");
    clr_stop();
    expect1(arb_lost, 0, "R8", "loss cleared with stop flag");

    // R9 stop flag clear without stop flag
    bus_start();
    request(1);
    slave_hit = 1; tick();
    clr_stop();
    expect1(arb_lost, 1, "R9", "loss kept, stop flag was 0");
    irq_clr = 1; tick();
    bus_stop();
    clr_stop();

    // R10 cancel while parked
    bus_start();
    request(1);
    request(0);
    expect1(master_req | active, 0, "R10", "cancel parked request");
    bus_stop();
    clr_stop();

    // R4 slave busy parks too
    slave_busy = 1;
    request(1);
    expect1(master_req & !active, 1, "R4", "parked on slave busy");
    slave_busy = 0;
    tick();
    expect1(active & start_go, 1, "R4", "start after slave idle");
    bus_start();

    // R1 disable
    en = 0; tick();
    expect1(master_req | active | bus_busy | arb_lost | irq_flag, 0, "R1", "disable clears");
    en = 1; tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule